// File: doc/BRIEF.md
# CAN Remote Frame Auto-Responder

This block sits next to the message buffer array of a CAN controller and answers remote requests without help from software. When the controller reports a fully received remote frame, the block takes its identifier and its format flag. It then reads the buffer array one slot per clock and looks for a transmit slot that is armed for automatic answers and carries exactly the same identifier. If a slot matches, the block raises a one-cycle response request that names the slot. A flag beside the request tells the controller whether to send a data frame from the slot's contents or a remote frame.

The incoming remote frame is only a trigger. The block has no write path into the buffers, so a request is never stored. Acceptance masks play no part in the match. The block does not handle framing, arbitration or the buffer storage itself. The buffer array is read through a combinational port that the block addresses with `bufSel`.

Top module: `rfr_responder`

## Requirements
- R1: A buffer takes part in the match only when its 4-bit code field equals 4'b1010. Any other code value never produces a response.
- R2: Identifiers are compared bit for bit. For an extended request (IDE=1), all 29 bits `[28:0]` must be equal. For a standard request (IDE=0), only bits `[10:0]` of the request and of the buffer are compared, and bits `[28:11]` are ignored.
- R3: The buffer's IDE flag must equal the request's IDE flag. A standard request never matches an extended buffer, and an extended request never matches a standard buffer.
- R4: The buffer's RTR bit is not part of the comparison. `respRemote` is 0 when the matching buffer's RTR bit is 0 (data frame answer) and 1 when it is 1 (remote frame answer).
- R5: When several buffers match, `respIdx` gives the lowest matching index.
- R6: When no buffer matches, `respValid` stays low and nothing else happens.
- R7: A strobe on `rxValid` starts a search only when `rxRtr` is 1. A received data frame (`rxRtr`=0) is ignored.
- R8: After an accepted strobe in cycle c, `busy` is high in cycles c+1 to c+N. During those cycles `bufSel` counts 0 to N-1. On a match, `respValid` is high for exactly one cycle, in cycle c+N+1.
- R9: A strobe that arrives while `busy` is high is ignored. The search in progress keeps its own identifier and finishes with its own result.
- R10: After reset, `busy` and `respValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a frame has been received |
| rxRtr | input | 1 | The received frame is a remote frame |
| rxIde | input | 1 | The received identifier is extended |
| rxId | input | ID_W (29) | Received identifier; standard IDs occupy [10:0] |
| bufSel | output | SEL_W (3) | Index of the buffer being read |
| bufCode | input | 4 | Code field of the selected buffer |
| bufId | input | ID_W (29) | Identifier of the selected buffer |
| bufIde | input | 1 | IDE flag of the selected buffer |
| bufRtr | input | 1 | RTR bit of the selected buffer |
| busy | output | 1 | Search in progress |
| respValid | output | 1 | One-cycle response request |
| respIdx | output | SEL_W (3) | Buffer chosen for the response |
| respRemote | output | 1 | 1: answer with a remote frame, 0: answer with a data frame |

## Verification
The assertions assume that the buffer read port returns the contents of the slot named by `bufSel` in the same cycle. They also assume that the buffer contents do not change while a search is running. The bench models the array combinationally from `bufSel`. It rewrites buffer contents only while `busy` is low, after any response pulse has been observed. Random trials draw identifiers from a small pool so that matches, multiple matches and misses all occur. Strobes are always single-cycle pulses, except where a second strobe during a search is injected on purpose.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  localparam logic [3:0] ANSWER_CODE = 4'b1010;
  localparam int STD_ID_W = 11;

  typedef struct packed {
    logic load;
    logic scan;
    logic done;
  } ctlStrb_t;
endpackage

// File: rtl/rfr_ctrl.sv
module rfr_ctrl
  import rfr_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  localparam int SEL_W = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxRtr,
  output ctlStrb_t         strb,
  output logic [SEL_W-1:0] scanIdx,
  output logic             busy
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_BUFS - 1);

  typedef enum logic {IDLE, SCAN} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      scanIdx <= '0;
    end else begin
      case (state)
        IDLE: if (rxValid && rxRtr) begin
          state   <= SCAN;
          scanIdx <= '0;
        end
        SCAN: if (scanIdx == LAST) begin
          state <= IDLE;
        end else begin
          scanIdx <= scanIdx + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = (state == IDLE) && rxValid && rxRtr;
    strb.scan = (state == SCAN);
    strb.done = (state == SCAN) && (scanIdx == LAST);
    busy      = (state == SCAN);
  end

  assert_scan_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && (scanIdx != LAST) |=> busy && (scanIdx == $past(scanIdx) + 1'b1));
  assert_scan_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && (scanIdx == LAST) |=> !busy);
  assert_start_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> scanIdx == '0);
endmodule

// File: rtl/rfr_datapath.sv
module rfr_datapath
  import rfr_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  parameter int ID_W = 29,
  localparam int SEL_W = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrb_t         strb,
  input  logic [SEL_W-1:0] scanIdx,
  input  logic [ID_W-1:0]  rxId,
  input  logic             rxIde,
  input  logic [3:0]       bufCode,
  input  logic [ID_W-1:0]  bufId,
  input  logic             bufIde,
  input  logic             bufRtr,
  output logic             respValid,
  output logic [SEL_W-1:0] respIdx,
  output logic             respRemote
);
  localparam logic [ID_W-1:0] STD_MASK = {{(ID_W-STD_ID_W){1'b0}}, {STD_ID_W{1'b1}}};

  logic [ID_W-1:0] reqId;
  logic            reqIde;
  logic            hit;
  logic [ID_W-1:0] idMask;
  logic            match;

  always_comb begin
    idMask = reqIde ? '1 : STD_MASK;
    match  = (bufCode == ANSWER_CODE) && (bufIde == reqIde) &&
             (((bufId ^ reqId) & idMask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqId      <= '0;
      reqIde     <= 1'b0;
      hit        <= 1'b0;
      respIdx    <= '0;
      respRemote <= 1'b0;
      respValid  <= 1'b0;
    end else begin
      respValid <= strb.done && (hit || match);
      if (strb.load) begin
        reqId  <= rxId;
        reqIde <= rxIde;
        hit    <= 1'b0;
      end else if (strb.scan && !hit && match) begin
        hit        <= 1'b1;
        respIdx    <= scanIdx;
        respRemote <= bufRtr;
      end
    end
  end

  always_comb begin
    assert_strobe_excl_R9: assert (!(strb.load && strb.scan));
  end

  assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
  assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.scan && !strb.done |=> $stable(reqId) && $stable(reqIde));
  assert_first_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.scan && hit |=> $stable(respIdx) && $stable(respRemote));
endmodule

// File: rtl/rfr_responder.sv
module rfr_responder
  import rfr_pkg::*;
#(
  parameter int NUM_BUFS = 8,
  parameter int ID_W = 29,
  localparam int SEL_W = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rxRtr,
  input  logic             rxIde,
  input  logic [ID_W-1:0]  rxId,
  output logic [SEL_W-1:0] bufSel,
  input  logic [3:0]       bufCode,
  input  logic [ID_W-1:0]  bufId,
  input  logic             bufIde,
  input  logic             bufRtr,
  output logic             busy,
  output logic             respValid,
  output logic [SEL_W-1:0] respIdx,
  output logic             respRemote
);
  ctlStrb_t         strb;
  logic [SEL_W-1:0] scanIdx;

  rfr_ctrl #(.NUM_BUFS(NUM_BUFS)) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxRtr(rxRtr),
    .strb(strb), .scanIdx(scanIdx), .busy(busy)
  );

  rfr_datapath #(.NUM_BUFS(NUM_BUFS), .ID_W(ID_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx),
    .rxId(rxId), .rxIde(rxIde), .bufCode(bufCode), .bufId(bufId),
    .bufIde(bufIde), .bufRtr(bufRtr), .respValid(respValid),
    .respIdx(respIdx), .respRemote(respRemote)
  );

  assign bufSel = scanIdx;

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> !busy && !respValid);
  assert_resp_after_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy || $rose(busy));
endmodule

// File: tb/sim_rfr_responder.sv
module sim_rfr_responder;
  localparam int N = 8;
  localparam int W = 29;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0, rxRtr = 1'b0, rxIde = 1'b0;
  logic [W-1:0] rxId = '0;
  logic [SW-1:0] bufSel;
  logic [3:0] bufCode;
  logic [W-1:0] bufId;
  logic bufIde, bufRtr;
  logic busy, respValid, respRemote;
  logic [SW-1:0] respIdx;

  logic [3:0] bCode [N];
  logic [W-1:0] bId [N];
  logic bIde [N];
  logic bRtr [N];

  assign bufCode = bCode[bufSel];
  assign bufId   = bId[bufSel];
  assign bufIde  = bIde[bufSel];
  assign bufRtr  = bRtr[bufSel];

  rfr_responder #(.NUM_BUFS(N), .ID_W(W)) u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxRtr(rxRtr), .rxIde(rxIde),
    .rxId(rxId), .bufSel(bufSel), .bufCode(bufCode), .bufId(bufId),
    .bufIde(bufIde), .bufRtr(bufRtr), .busy(busy), .respValid(respValid),
    .respIdx(respIdx), .respRemote(respRemote)
  );

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  int cycleCnt = 0;
  int pulseCnt = 0, pulseCycle = -1;
  int lastIdx = 0;
  logic lastRemote = 1'b0;
  bit finished = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  always @(negedge clk) if (respValid) begin
    pulseCnt++;
    pulseCycle = cycleCnt;
    lastIdx = int'(respIdx);
    lastRemote = respRemote;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit refMatch(input int k, input logic [W-1:0] id, input logic ide,
                                  output int idx, output logic rem);
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] m;
      m = ide ? '1 : W'(11'h7FF);
      if (bCode[i] == 4'b1010 && bIde[i] == ide && ((bId[i] ^ id) & m) == '0) begin
        idx = i; rem = bRtr[i];
        return 1'b1;
      end
    end
    idx = 0; rem = 1'b0;
    return 1'b0;
  endfunction

  task automatic clearBufs();
    for (int i = 0; i < N; i++) begin
      bCode[i] = 4'b0000; bId[i] = '0; bIde[i] = 1'b0; bRtr[i] = 1'b0;
    end
  endtask

  // Issue one request and check the outcome against the model.
  task automatic request(input logic [W-1:0] id, input logic ide, input logic rtr,
                         input bit midStrobe, input string req);
    int s, eIdx;
    logic eRem;
    bit eHit, selOk;
    eHit = rtr ? refMatch(0, id, ide, eIdx, eRem) : 1'b0;
    @(negedge clk);
    pulseCnt = 0; pulseCycle = -1;
    s = cycleCnt;
    rxValid = 1'b1; rxRtr = rtr; rxIde = ide; rxId = id;
    @(negedge clk);
    rxValid = 1'b0;
    selOk = 1;
    if (rtr) begin
      for (int k = 0; k < N; k++) begin
        if (k > 0) @(negedge clk);
        if (!busy || int'(bufSel) != k) selOk = 0;
        if (midStrobe && k == 2) begin
          rxValid = 1'b1; rxRtr = 1'b1; rxIde = ~ide; rxId = ~id;
        end else rxValid = 1'b0;
      end
      check(selOk, "R8 busy/bufSel sequence", int'(bufSel), N-1);
    end
    repeat (N + 4) @(negedge clk);
    check(!busy, "R8 busy released", busy, 0);
    check(pulseCnt == (eHit ? 1 : 0), req, pulseCnt, eHit ? 1 : 0);
    if (eHit && pulseCnt == 1) begin
      check(pulseCycle - s == N + 1, "R8 response cycle", pulseCycle - s, N + 1);
      check(lastIdx == eIdx, {req, " idx"}, lastIdx, eIdx);
      check(lastRemote == eRem, {req, " R4 remote flag"}, lastRemote, eRem);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !respValid, "R10 reset state", busy | respValid, 0);
    rstN = 1'b1;
    clearBufs();

    // R1: matching id but wrong code, then right code
    bId[3] = 29'h123; bCode[3] = 4'b1000;
    request(29'h123, 1'b0, 1'b1, 0, "R1 wrong code ignored");
    bCode[3] = 4'b1010;
    request(29'h123, 1'b0, 1'b1, 0, "R1 answer code matches");
    // R4: remote answer
    bRtr[3] = 1'b1;
    request(29'h123, 1'b0, 1'b1, 0, "R4 remote answer");
    // R2: standard ignores upper bits, extended compares them
    request(29'h1F000123, 1'b0, 1'b1, 0, "R2 std upper bits ignored");
    clearBufs();
    bCode[5] = 4'b1010; bIde[5] = 1'b1; bId[5] = 29'h1ABCDEF0;
    request(29'h1ABCDEF0, 1'b1, 1'b1, 0, "R2 extended exact");
    request(29'h0ABCDEF0, 1'b1, 1'b1, 0, "R2 extended top bit differs");
    // R3: IDE mismatch
    request(29'h1ABCDEF0, 1'b0, 1'b1, 0, "R3 ide mismatch");
    // R5: several matches
    bCode[2] = 4'b1010; bIde[2] = 1'b1; bId[2] = 29'h1ABCDEF0; bRtr[2] = 1'b1;
    bCode[7] = 4'b1010; bIde[7] = 1'b1; bId[7] = 29'h1ABCDEF0;
    request(29'h1ABCDEF0, 1'b1, 1'b1, 0, "R5 lowest index");
    // R6: no match
    request(29'h0000055, 1'b1, 1'b1, 0, "R6 no match silent");
    // R7: data frame ignored
    request(29'h1ABCDEF0, 1'b1, 1'b0, 0, "R7 data frame ignored");
    check(!busy, "R7 no search started", busy, 0);
    // R9: strobe during search ignored (second id would hit buffer 0)
    bCode[0] = 4'b1010; bIde[0] = 1'b0; bId[0] = ~29'h1ABCDEF0 & 29'h7FF;
    request(29'h1ABCDEF0, 1'b1, 1'b1, 1, "R9 busy strobe ignored");
    // Boundary: match only in last slot, then first slot
    clearBufs();
    bCode[N-1] = 4'b1010; bId[N-1] = 29'h7FF;
    request(29'h7FF, 1'b0, 1'b1, 0, "R8 last slot");
    bCode[0] = 4'b1010; bId[0] = 29'h000;
    request(29'h000, 1'b0, 1'b1, 0, "R5 first slot");

    // Random trials
    void'($urandom(1234));
    for (int t = 0; t < 60; t++) begin
      logic [W-1:0] pool [4];
      pool[0] = 29'h0A5; pool[1] = 29'h1555_0A5; pool[2] = 29'h3FF; pool[3] = 29'h1000_3FF;
      for (int i = 0; i < N; i++) begin
        bCode[i] = ($urandom % 2) ? 4'b1010 : 4'($urandom);
        bId[i]   = pool[$urandom % 4];
        bIde[i]  = 1'($urandom);
        bRtr[i]  = 1'($urandom);
      end
      request(pool[$urandom % 4], 1'($urandom), ($urandom % 8) != 0, 0, "R2 R3 R5 random");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule